// File: doc/BRIEF.md
# Interrupt Acknowledge Responder

This block is the bus-side interrupt unit of a two-channel serial peripheral. Each channel raises requests on three levels: receive (level 0), transmit (level 1) and modem/status (level 2). A request stays pending until the host clears it with an end-of-service write. A level's active-low request output is pulled low while either channel has that level pending. The host also loads a 7-bit match value for each level and an 8-bit vector for each channel through a small configuration write port.

An acknowledge cycle opens when the acknowledge input and the data strobe are both low while chip select is high. The block compares the address bits with the match value of every pending level. If a level matches, the block latches a vector and drives it on the data bus, then asserts data-acknowledge until the strobe rises. The vector has bits [7:2] from the winning channel's vector register and bits [1:0] set to the level code. If no level matches, the block passes the acknowledge on by pulling its acknowledge-out output low until the acknowledge input rises. Several levels may share one match value. A fixed order then picks the level, and channel 0 wins over channel 1 within a level.

Top module: `iack_responder`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), all irq_n bits are 1, dtack_n is 1, iack_out_n is 1, data_oe is 0 and no request is pending.
- R2: A one-cycle pulse on req_set bit c*3+l (c = channel, l = level) sets that request pending. irq_n[l] reads 0 from the cycle after the edge and stays 0 while any channel has level l pending.
- R3: A write with cfg_sel=5 is an end-of-service command. cfg_wdata[2] is the channel and cfg_wdata[1:0] is the level. It clears that request. Level code 3 is ignored, and an acknowledge cycle never clears a request.
- R4: An acknowledge cycle starts only when iack_n=0, ds_n=0 and cs_n=1 are sampled together. With cs_n=0 the block asserts neither dtack_n nor iack_out_n.
- R5: A level is eligible when it is pending and addr equals its match register (cfg_sel=0..2 loads bits [6:0] for levels 0..2). One cycle after a start with an eligible level, dtack_n=0 and data_oe=1. At the same time data_out = {vector[7:2], level[1:0]}, where cfg_sel=3 loads the vector of channel 0 and cfg_sel=4 loads the vector of channel 1.
- R6: When several eligible levels match the address, the lowest level number wins.
- R7: Within the winning level, channel 0 wins over channel 1.
- R8: dtack_n stays 0 while ds_n is sampled 0. It returns to 1, and data_oe to 0, one cycle after ds_n is sampled 1.
- R9: data_out holds the value latched at the start for the whole answer, even if a vector register is rewritten meanwhile.
- R10: A start with no eligible level drives iack_out_n=0 one cycle later, with dtack_n kept at 1. iack_out_n stays 0 until iack_n is sampled 1 and returns to 1 on the next cycle.
- R11: dtack_n and iack_out_n are never 0 at the same time.
- R12: A req_set pulse and an end-of-service write for the same request in one cycle leave it pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_set | input | 6 | Request set pulses, bit c*3+l |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration target select |
| cfg_wdata | input | 8 | Configuration write data |
| iack_n | input | 1 | Acknowledge input, active low |
| ds_n | input | 1 | Data strobe, active low |
| cs_n | input | 1 | Chip select, active low |
| addr | input | 7 | Low address bits compared during acknowledge |
| irq_n | output | 3 | Per-level requests, 0 = pull low, 1 = released |
| iack_out_n | output | 1 | Acknowledge passed down the chain, active low |
| dtack_n | output | 1 | Data acknowledge, active low |
| data_oe | output | 1 | Data bus output enable |
| data_out | output | 8 | Vector driven while data_oe is 1 |

## Verification
Each result is due one clock after the stimulus that causes it. A request pulse shows on irq_n one cycle later. A start shows on dtack_n/data_oe/data_out or on iack_out_n one cycle later. A rising strobe or acknowledge input shows as a release one cycle later. The bench changes inputs on the falling edge, so every value is sampled at the next rising edge. On the following falling edge it compares all outputs with a behavioural reference model that keeps pending flags, match values and vectors in plain arrays. The directed checks are placed on that same falling edge, exactly one clock after the stimulus they test.

// File: rtl/iack_pkg.sv
// Shared types for the interrupt acknowledge responder.
package iack_pkg;
    // Phase of the acknowledge handshake.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SERVE = 2'd1,
        ST_PASS  = 2'd2
    } ack_state_e;
endpackage

// File: rtl/iack_cfg_regs.sv
// Configuration registers: one match value per level and one vector per
// channel, plus decode of the end-of-service command.
// Assumes: the select layout is levels first, then channels, then the command.
module iack_cfg_regs #(
    parameter int NUM_CH  = 2,
    parameter int NUM_LVL = 3,
    parameter int ADDR_W  = 7,
    parameter int VEC_W   = 8,
    parameter int SEL_W   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [SEL_W-1:0]            cfg_sel,
    input  logic [VEC_W-1:0]            cfg_wdata,
    output logic [NUM_LVL*ADDR_W-1:0]   match_flat,
    output logic [NUM_CH*VEC_W-1:0]     vec_flat,
    output logic                        eos_valid,
    output logic [((NUM_CH>1)?$clog2(NUM_CH):1)-1:0]   eos_ch,
    output logic [((NUM_LVL>1)?$clog2(NUM_LVL):1)-1:0] eos_lvl
);
    localparam int LVL_W   = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1;
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int SEL_VEC = NUM_LVL;
    localparam int SEL_EOS = NUM_LVL + NUM_CH;

    // Per-level match registers.
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_match
        logic [ADDR_W-1:0] m_q;
        // Load the level's match value on a write to its select.
        always_ff @(posedge clk) begin
            if (!rst_n)
                m_q <= '0;
            else if (cfg_we && cfg_sel == SEL_W'(l))
                m_q <= cfg_wdata[ADDR_W-1:0];
        end
        assign match_flat[l*ADDR_W +: ADDR_W] = m_q;
    end

    // Per-channel vector registers.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_vec
        logic [VEC_W-1:0] v_q;
        // Load the channel's vector on a write to its select.
        always_ff @(posedge clk) begin
            if (!rst_n)
                v_q <= '0;
            else if (cfg_we && cfg_sel == SEL_W'(SEL_VEC + c))
                v_q <= cfg_wdata;
        end
        assign vec_flat[c*VEC_W +: VEC_W] = v_q;
    end

    // Decode end-of-service fields and reject codes outside the range.
    assign eos_lvl = cfg_wdata[LVL_W-1:0];
    assign eos_ch  = cfg_wdata[LVL_W +: CH_W];
    assign eos_valid = cfg_we && (cfg_sel == SEL_W'(SEL_EOS))
                    && ({1'b0, eos_lvl} < (LVL_W+1)'(NUM_LVL))
                    && ({1'b0, eos_ch}  < (CH_W+1)'(NUM_CH));
endmodule

// File: rtl/iack_pending.sv
// Pending request flags per channel and level, and the per-level
// active-low request outputs. A set pulse wins over a same-cycle clear.
module iack_pending #(
    parameter int NUM_CH  = 2,
    parameter int NUM_LVL = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH*NUM_LVL-1:0] req_set,
    input  logic                      eos_valid,
    input  logic [((NUM_CH>1)?$clog2(NUM_CH):1)-1:0]   eos_ch,
    input  logic [((NUM_LVL>1)?$clog2(NUM_LVL):1)-1:0] eos_lvl,
    output logic [NUM_CH*NUM_LVL-1:0] pend_flat,
    output logic [NUM_LVL-1:0]        irq_n
);
    localparam int LVL_W = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1;
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
            logic p_q;
            logic clr;
            assign clr = eos_valid && (eos_ch == CH_W'(c)) && (eos_lvl == LVL_W'(l));
            // Hold one request flag: set by the engine, cleared by the host.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    p_q <= 1'b0;
                else if (req_set[c*NUM_LVL + l])
                    p_q <= 1'b1;
                else if (clr)
                    p_q <= 1'b0;
            end
            assign pend_flat[c*NUM_LVL + l] = p_q;
        end
    end

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_irq
        logic any_p;
        // Merge the channels' flags of one level.
        always_comb begin
            any_p = 1'b0;
            for (int c = 0; c < NUM_CH; c++)
                any_p = any_p | pend_flat[c*NUM_LVL + l];
        end
        assign irq_n[l] = ~any_p;
    end
endmodule

// File: rtl/iack_arbiter.sv
// Combinational match and priority: picks the lowest eligible level whose
// match value equals the address, and within it the lowest channel.
module iack_arbiter #(
    parameter int NUM_CH  = 2,
    parameter int NUM_LVL = 3,
    parameter int ADDR_W  = 7
) (
    input  logic [NUM_CH*NUM_LVL-1:0] pend_flat,
    input  logic [NUM_LVL*ADDR_W-1:0] match_flat,
    input  logic [ADDR_W-1:0]         addr,
    output logic                      hit,
    output logic [((NUM_LVL>1)?$clog2(NUM_LVL):1)-1:0] sel_lvl,
    output logic [((NUM_CH>1)?$clog2(NUM_CH):1)-1:0]   sel_ch
);
    localparam int LVL_W = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1;
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [NUM_LVL-1:0]      lvl_ok;
    logic [NUM_LVL*CH_W-1:0] lvl_ch;

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        logic          any_p;
        logic [CH_W-1:0] ch_pick;
        // Lowest pending channel of this level.
        always_comb begin
            any_p   = 1'b0;
            ch_pick = '0;
            for (int c = NUM_CH - 1; c >= 0; c--) begin
                if (pend_flat[c*NUM_LVL + l]) begin
                    any_p   = 1'b1;
                    ch_pick = CH_W'(c);
                end
            end
        end
        assign lvl_ok[l] = any_p && (addr == match_flat[l*ADDR_W +: ADDR_W]);
        assign lvl_ch[l*CH_W +: CH_W] = ch_pick;
    end

    // Fixed priority across levels: lowest index wins.
    always_comb begin
        hit     = 1'b0;
        sel_lvl = '0;
        sel_ch  = '0;
        for (int l = NUM_LVL - 1; l >= 0; l--) begin
            if (lvl_ok[l]) begin
                hit     = 1'b1;
                sel_lvl = LVL_W'(l);
                sel_ch  = lvl_ch[l*CH_W +: CH_W];
            end
        end
    end
endmodule

// File: rtl/iack_cycle_fsm.sv
// Acknowledge handshake: answers with a latched vector and data-acknowledge,
// or passes the acknowledge down the chain. All outputs come from registers.
// Assumes: strobe, acknowledge and chip select are already synchronous to clk.
module iack_cycle_fsm #(
    parameter int NUM_CH  = 2,
    parameter int NUM_LVL = 3,
    parameter int VEC_W   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    iack_n,
    input  logic                    ds_n,
    input  logic                    cs_n,
    input  logic                    hit,
    input  logic [((NUM_LVL>1)?$clog2(NUM_LVL):1)-1:0] sel_lvl,
    input  logic [((NUM_CH>1)?$clog2(NUM_CH):1)-1:0]   sel_ch,
    input  logic [NUM_CH*VEC_W-1:0] vec_flat,
    output logic                    dtack_n,
    output logic                    iack_out_n,
    output logic                    data_oe,
    output logic [VEC_W-1:0]        data_out
);
    import iack_pkg::*;
    localparam int LVL_W = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1;
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    ack_state_e       state_q, state_d;
    logic [VEC_W-1:0] data_q;
    logic [VEC_W-1:0] vec_pick;
    logic             start;

    assign start = !iack_n && !ds_n && cs_n;

    // Select the winning channel's vector register.
    always_comb begin
        vec_pick = '0;
        for (int c = 0; c < NUM_CH; c++)
            if (sel_ch == CH_W'(c))
                vec_pick = vec_flat[c*VEC_W +: VEC_W];
    end

    // Next phase of the handshake.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (start) state_d = hit ? ST_SERVE : ST_PASS;
            ST_SERVE: if (ds_n) state_d = ST_IDLE;
            ST_PASS:  if (iack_n) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Latch the answer vector once, at the start of a served cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (state_q == ST_IDLE && start && hit)
            data_q <= {vec_pick[VEC_W-1:LVL_W], sel_lvl};
    end

    assign dtack_n    = (state_q != ST_SERVE);
    assign data_oe    = (state_q == ST_SERVE);
    assign iack_out_n = (state_q != ST_PASS);
    assign data_out   = data_oe ? data_q : '0;
endmodule

// File: rtl/iack_responder.sv
// Top of the interrupt acknowledge responder: configuration, pending
// requests, match/priority and the acknowledge handshake.
module iack_responder #(
    parameter int NUM_CH  = 2,
    parameter int NUM_LVL = 3,
    parameter int ADDR_W  = 7,
    parameter int VEC_W   = 8,
    parameter int SEL_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH*NUM_LVL-1:0] req_set,
    input  logic                      cfg_we,
    input  logic [SEL_W-1:0]          cfg_sel,
    input  logic [VEC_W-1:0]          cfg_wdata,
    input  logic                      iack_n,
    input  logic                      ds_n,
    input  logic                      cs_n,
    input  logic [ADDR_W-1:0]         addr,
    output logic [NUM_LVL-1:0]        irq_n,
    output logic                      iack_out_n,
    output logic                      dtack_n,
    output logic                      data_oe,
    output logic [VEC_W-1:0]          data_out
);
    localparam int LVL_W = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1;
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [NUM_LVL*ADDR_W-1:0] match_flat;
    logic [NUM_CH*VEC_W-1:0]   vec_flat;
    logic                      eos_valid;
    logic [CH_W-1:0]           eos_ch;
    logic [LVL_W-1:0]          eos_lvl;
    logic [NUM_CH*NUM_LVL-1:0] pend_flat;
    logic                      hit;
    logic [LVL_W-1:0]          sel_lvl;
    logic [CH_W-1:0]           sel_ch;

    iack_cfg_regs #(.NUM_CH(NUM_CH), .NUM_LVL(NUM_LVL), .ADDR_W(ADDR_W),
                    .VEC_W(VEC_W), .SEL_W(SEL_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .match_flat(match_flat), .vec_flat(vec_flat),
        .eos_valid(eos_valid), .eos_ch(eos_ch), .eos_lvl(eos_lvl)
    );

    iack_pending #(.NUM_CH(NUM_CH), .NUM_LVL(NUM_LVL)) u_pend (
        .clk(clk), .rst_n(rst_n), .req_set(req_set), .eos_valid(eos_valid),
        .eos_ch(eos_ch), .eos_lvl(eos_lvl), .pend_flat(pend_flat), .irq_n(irq_n)
    );

    iack_arbiter #(.NUM_CH(NUM_CH), .NUM_LVL(NUM_LVL), .ADDR_W(ADDR_W)) u_arb (
        .pend_flat(pend_flat), .match_flat(match_flat), .addr(addr),
        .hit(hit), .sel_lvl(sel_lvl), .sel_ch(sel_ch)
    );

    iack_cycle_fsm #(.NUM_CH(NUM_CH), .NUM_LVL(NUM_LVL), .VEC_W(VEC_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .iack_n(iack_n), .ds_n(ds_n), .cs_n(cs_n),
        .hit(hit), .sel_lvl(sel_lvl), .sel_ch(sel_ch), .vec_flat(vec_flat),
        .dtack_n(dtack_n), .iack_out_n(iack_out_n), .data_oe(data_oe),
        .data_out(data_out)
    );
endmodule

// File: rtl/iack_responder_chk.sv
// Protocol checks on the responder's ports, attached by bind.
module iack_responder_chk #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iack_n,
    input logic             ds_n,
    input logic             cs_n,
    input logic             dtack_n,
    input logic             iack_out_n,
    input logic             data_oe,
    input logic [VEC_W-1:0] data_out
);
    // R11: never answer and pass at once.
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dtack_n && !iack_out_n));

    // R8: data-acknowledge held while the strobe stays low.
    a_r8_dtack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && !ds_n) |=> !dtack_n);

    // R8: data-acknowledge released after the strobe rises.
    a_r8_dtack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && ds_n) |=> dtack_n);

    // R10: pass-on held while acknowledge-in stays low.
    a_r10_pass_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!iack_out_n && !iack_n) |=> !iack_out_n);

    // R10: pass-on released after acknowledge-in rises.
    a_r10_pass_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!iack_out_n && iack_n) |=> iack_out_n);

    // R4: chip select blocks the start of a cycle.
    a_r4_cs_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (dtack_n && iack_out_n && !cs_n) |=> (dtack_n && iack_out_n));

    // R5: a valid start always gets an answer or a pass-on.
    a_r5_start_answered: assert property (@(posedge clk) disable iff (!rst_n)
        (dtack_n && iack_out_n && !iack_n && !ds_n && cs_n) |=> (!dtack_n || !iack_out_n));

    // R9: vector stays put during an answer.
    a_r9_vector_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && $past(data_oe)) |-> $stable(data_out));
endmodule

bind iack_responder iack_responder_chk #(.VEC_W(VEC_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .iack_n(iack_n), .ds_n(ds_n), .cs_n(cs_n),
    .dtack_n(dtack_n), .iack_out_n(iack_out_n), .data_oe(data_oe),
    .data_out(data_out)
);

// File: tb/test_iack_responder.sv
module test_iack_responder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] req_set = '0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic       iack_n = 1'b1;
    logic       ds_n = 1'b1;
    logic       cs_n = 1'b1;
    logic [6:0] addr = '0;
    logic [2:0] irq_n;
    logic       iack_out_n, dtack_n, data_oe;
    logic [7:0] data_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit model_on = 0;

    // Reference model state.
    bit         pend[2][3];
    logic [6:0] mm[3];
    logic [7:0] vv[2];
    int         mode;      // 0 idle, 1 answering, 2 passing on
    logic [7:0] exp_d;

    always #5 clk = ~clk;

    iack_responder i_iack_responder (
        .clk(clk), .rst_n(rst_n), .req_set(req_set), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .iack_n(iack_n), .ds_n(ds_n),
        .cs_n(cs_n), .addr(addr), .irq_n(irq_n), .iack_out_n(iack_out_n),
        .dtack_n(dtack_n), .data_oe(data_oe), .data_out(data_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (pend[c, l]) pend[c][l] = 0;
            foreach (mm[l]) mm[l] = '0;
            foreach (vv[c]) vv[c] = '0;
            mode = 0;
            exp_d = '0;
        end else begin
            case (mode)
                0: if (!iack_n && !ds_n && cs_n) begin
                    int win_l;
                    win_l = -1;
                    for (int l = 0; l < 3; l++)
                        if (win_l < 0 && (pend[0][l] || pend[1][l]) && addr == mm[l])
                            win_l = l;
                    if (win_l >= 0) begin
                        int wc;
                        wc = pend[0][win_l] ? 0 : 1;
                        exp_d = {vv[wc][7:2], 2'(win_l)};
                        mode = 1;
                    end else
                        mode = 2;
                end
                1: if (ds_n) mode = 0;
                2: if (iack_n) mode = 0;
                default: mode = 0;
            endcase
            if (cfg_we) begin
                if (cfg_sel < 3) mm[cfg_sel] = cfg_wdata[6:0];
                else if (cfg_sel == 3) vv[0] = cfg_wdata;
                else if (cfg_sel == 4) vv[1] = cfg_wdata;
                else if (cfg_sel == 5 && cfg_wdata[1:0] != 2'd3)
                    pend[cfg_wdata[2]][cfg_wdata[1:0]] = 0;
            end
            for (int i = 0; i < 6; i++)
                if (req_set[i]) pend[i / 3][i % 3] = 1;
        end
    end

    // Per-cycle comparison of every output with the model.
    always @(negedge clk) begin
        if (model_on && !done) begin
            logic [2:0] ei;
            for (int l = 0; l < 3; l++) ei[l] = !(pend[0][l] || pend[1][l]);
            chk("R2 irq_n model", 32'(irq_n), 32'(ei));
            chk("R8 dtack_n model", 32'(dtack_n), 32'(mode != 1));
            chk("R5 data_oe model", 32'(data_oe), 32'(mode == 1));
            chk("R10 iack_out_n model", 32'(iack_out_n), 32'(mode != 2));
            if (mode == 1) chk("R9 data_out model", 32'(data_out), 32'(exp_d));
        end
    end

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic cfg(input logic [3:0] s, input logic [7:0] d);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        tick;
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input logic [5:0] b);
        req_set = b;
        tick;
        req_set = '0;
    endtask

    task automatic serve(input logic [6:0] a, input logic [7:0] expd, input string tag);
        iack_n = 1'b0; ds_n = 1'b0; cs_n = 1'b1; addr = a;
        tick;
        chk({tag, " dtack_n"}, 32'(dtack_n), 32'd0);
        chk({tag, " data_out"}, 32'(data_out), 32'(expd));
        chk("R11 no pass while answering", 32'(iack_out_n), 32'd1);
        ds_n = 1'b1; iack_n = 1'b1;
        tick;
        chk("R8 release", 32'(dtack_n), 32'd1);
    endtask

    initial begin
        repeat (2) tick;
        rst_n = 1'b1;
        tick;
        model_on = 1;
        // R1 reset state
        chk("R1 irq_n", 32'(irq_n), 32'h7);
        chk("R1 dtack_n", 32'(dtack_n), 32'd1);
        chk("R1 iack_out_n", 32'(iack_out_n), 32'd1);
        chk("R1 data_oe", 32'(data_oe), 32'd0);

        cfg(4'd0, 8'h11); cfg(4'd1, 8'h22); cfg(4'd2, 8'h33);
        cfg(4'd3, 8'hA0); cfg(4'd4, 8'hB4);

        // R2: channel 1, level 1
        pulse(6'b010000);
        chk("R2 irq level 1", 32'(irq_n), 32'b101);

        // R4: chip select active blocks the cycle
        iack_n = 1'b0; ds_n = 1'b0; cs_n = 1'b0; addr = 7'h22;
        tick; tick;
        chk("R4 no dtack", 32'(dtack_n), 32'd1);
        chk("R4 no pass", 32'(iack_out_n), 32'd1);
        iack_n = 1'b1; ds_n = 1'b1; cs_n = 1'b1;
        tick;

        // R5 / R9: answer with level 1 of channel 1, rewrite vector meanwhile
        iack_n = 1'b0; ds_n = 1'b0; addr = 7'h22;
        tick;
        chk("R5 dtack_n", 32'(dtack_n), 32'd0);
        chk("R5 data_oe", 32'(data_oe), 32'd1);
        chk("R5 vector", 32'(data_out), 32'hB5);
        cfg(4'd4, 8'hFF);
        chk("R9 held vector", 32'(data_out), 32'hB5);
        chk("R8 held dtack", 32'(dtack_n), 32'd0);
        ds_n = 1'b1; iack_n = 1'b1;
        tick;
        chk("R8 dtack released", 32'(dtack_n), 32'd1);
        chk("R8 oe released", 32'(data_oe), 32'd0);
        chk("R3 ack keeps request", 32'(irq_n), 32'b101);

        // R10: no eligible level, pass on
        iack_n = 1'b0; ds_n = 1'b0; addr = 7'h11;
        tick;
        chk("R10 pass asserted", 32'(iack_out_n), 32'd0);
        chk("R11 no dtack while passing", 32'(dtack_n), 32'd1);
        ds_n = 1'b1;
        tick;
        chk("R10 pass held", 32'(iack_out_n), 32'd0);
        iack_n = 1'b1;
        tick;
        chk("R10 pass released", 32'(iack_out_n), 32'd1);

        // R6: shared match value, level order
        cfg(4'd0, 8'h40); cfg(4'd1, 8'h40); cfg(4'd2, 8'h40);
        pulse(6'b001100);
        serve(7'h40, 8'hFC, "R6 level 0 first");
        cfg(4'd5, 8'h04);
        serve(7'h40, 8'hFD, "R6 level 1 next");
        cfg(4'd5, 8'h05);
        serve(7'h40, 8'hA2, "R6 level 2 last");

        // R7: both channels at level 0
        pulse(6'b001001);
        serve(7'h40, 8'hA0, "R7 channel 0 first");

        // R3: level code 3 ignored
        chk("R3 before", 32'(irq_n), 32'b010);
        cfg(4'd5, 8'h03);
        chk("R3 code 3 ignored", 32'(irq_n), 32'b010);
        cfg(4'd5, 8'h00);
        chk("R3 clear ch0 lvl0 keeps ch1", 32'(irq_n), 32'b010);
        cfg(4'd5, 8'h04);
        chk("R3 level 0 cleared", 32'(irq_n), 32'b011);

        // R12: set and clear together
        cfg_we = 1'b1; cfg_sel = 4'd5; cfg_wdata = 8'h01; req_set = 6'b000010;
        tick;
        cfg_we = 1'b0; req_set = '0;
        chk("R12 set wins", 32'(irq_n), 32'b001);

        tick;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule